// File: doc/BRIEF.md
# Converter Result Serial Port

This block sends a stored 16-bit converter result out, one bit at a time, most significant bit first. It can be the clock source or follow someone else's clock. In master mode it makes the serial clock from the system clock and drives a frame sync signal that is active for the whole word. In slave mode it follows an external serial clock, which counts only while chip select is low.

A group of static mode inputs sets the behaviour:

- the clock source;
- which clock edge is active;
- the sync polarity;
- the read timing;
- the output number format.

With read-after-convert, each result goes out as soon as its conversion-done strobe arrives. With read-during-convert, the result latched at the last done strobe goes out when a conversion-start strobe arrives, while that next conversion is running.

In slave mode a daisy-chain input is shifted in behind the word. A second converter's result can therefore follow this one on the same line.

All slave-side inputs are brought into the system clock domain through synchronizer stages before edge detection. The external serial clock must therefore be several times slower than the system clock.

Top module: `adc_serial_port`

## Requirements
- R1: After reset, and whenever no transfer is running, `sdout_o` is 0, `sclk_o` equals `clk_inv_i` and `sync_o` equals `sync_inv_i`.
- R2: In master mode with `rd_during_i`=0, a pulse on `done_i` starts a 16-bit frame carrying the `result_i` value present with the strobe, most significant bit first.
- R3: With `twos_i`=1 the sent word is the stored word with its most significant bit inverted; with `twos_i`=0 it is sent unchanged.
- R4: In master mode the serial clock period is 2, 4, 8 or 16 system clocks for `div_sel_i` = 0, 1, 2, 3 when `rd_during_i`=0, and always 2 system clocks when `rd_during_i`=1.
- R5: In master mode `sync_o` is active for the whole frame and inactive after it: active high when `sync_inv_i`=0, active low when `sync_inv_i`=1.
- R6: In master mode the active (sampling) edge of `sclk_o` is rising when `clk_inv_i`=0 and falling when `clk_inv_i`=1, and `sdout_o` is stable at every active edge.
- R7: In master mode with `rd_during_i`=1, `done_i` only latches `result_i` and starts no frame. A pulse on `start_i` sends the word latched at the last `done_i`, ignoring the present `result_i`.
- R8: In slave mode, the transfer works as follows:
  - a falling `cs_n_i` loads the stored word and places its most significant bit on `sdout_o`;
  - each active `sclk_i` edge while `cs_n_i` is low moves to the next bit;
  - the active edge is rising for `clk_inv_i`=0 and falling for `clk_inv_i`=1.
- R9: In slave mode the level of `sdin_i` at an active edge is shifted in behind the word, so it appears on `sdout_o` 16 active edges later.
- R10: In slave mode `sdout_o` is 0 while `cs_n_i` is high. Raising `cs_n_i` mid-frame aborts the transfer, and the next falling `cs_n_i` restarts from the most significant bit.
- R11: In slave mode `done_i` and `start_i` start no master frame: `sclk_o` and `sync_o` stay at their idle levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| result_i | input | 16 | Converter result word (offset binary) |
| done_i | input | 1 | Conversion-done strobe, latches `result_i` |
| start_i | input | 1 | Conversion-start strobe (read-during-convert trigger) |
| ext_clk_sel_i | input | 1 | 0 master clocking, 1 slave clocking |
| clk_inv_i | input | 1 | 0 rising active edge, 1 falling active edge |
| sync_inv_i | input | 1 | 0 sync active high, 1 sync active low |
| rd_during_i | input | 1 | 0 read after convert, 1 read during next convert |
| twos_i | input | 1 | 1 selects two's complement output |
| div_sel_i | input | 2 | Master clock divide code |
| sclk_i | input | 1 | External serial clock (slave mode) |
| cs_n_i | input | 1 | Active-low chip select (slave mode) |
| sdin_i | input | 1 | Daisy-chain serial input (slave mode) |
| sclk_o | output | 1 | Generated serial clock (master mode) |
| sync_o | output | 1 | Frame sync (master mode) |
| sdout_o | output | 1 | Serial data output |

## Verification
The bench measures the master clock period at every divide code, and also with read-during selected while a nonzero divide code is applied. A design that fails to force the fast clock in that mode shows a stretched period. Some stimuli drive `done_i` in read-during mode, or present a new `result_i` without a strobe; a design that sends the live word or starts a frame on the done strobe fails the word comparison or the quiet-sync check. In slave mode the bench sends 31 edges and checks that the daisy-chain bits follow the word with exactly 16 edges of delay; an off-by-one shifter moves the whole stream. It also aborts a transfer after five bits and checks that the next select restarts at the most significant bit. A design that kept its position would resume mid-word.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;

   typedef enum logic {
      CLK_MASTER = 1'b0,
      CLK_SLAVE  = 1'b1
   } clk_src_e;

   typedef struct packed {
      clk_src_e src;
      logic     inv_clk;
      logic     inv_sync;
      logic     rd_during;
      logic     twos;
   } port_mode_t;

endpackage

// File: rtl/adc_sp_sync.sv
module adc_sp_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] pipe_q;

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe_q[g] <= RST_VAL;
               else        pipe_q[g] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe_q[g] <= RST_VAL;
               else        pipe_q[g] <= pipe_q[g-1];
            end
         end
      end
   endgenerate

   assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/adc_sp_master_clk.sv
module adc_sp_master_clk #(
   parameter int WIDTH = 16,
   parameter int DIV_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             active_o,
   output logic             phase_o,
   output logic             shift_o
);

   localparam int CNT_W = (1 << DIV_W) - 1;
   localparam int BIT_W = $clog2(WIDTH);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WIDTH - 1);

   logic             active_q;
   logic             phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic [BIT_W-1:0] bit_q;
   logic [CNT_W-1:0] half_last;
   logic             half_done;

   assign half_last = CNT_W'((32'd1 << div_i) - 32'd1);
   assign half_done = (cnt_q == half_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         phase_q  <= 1'b0;
         cnt_q    <= '0;
         bit_q    <= '0;
      end else if (!active_q) begin
         if (go_i) begin
            active_q <= 1'b1;
            phase_q  <= 1'b0;
            cnt_q    <= '0;
            bit_q    <= '0;
         end
      end else if (half_done) begin
         cnt_q <= '0;
         if (!phase_q) begin
            phase_q <= 1'b1;
         end else begin
            phase_q <= 1'b0;
            if (bit_q == LAST_BIT) active_q <= 1'b0;
            else                   bit_q    <= bit_q + 1'b1;
         end
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign active_o = active_q;
   assign phase_o  = phase_q;
   assign shift_o  = active_q & phase_q & half_done & (bit_q != LAST_BIT);

   AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active_q) |-> ($past(bit_q) == LAST_BIT)); // R2

   AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !active_q |-> !phase_q); // R6

   AST_SHIFT_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      shift_o |=> !shift_o); // R4

endmodule

// File: rtl/adc_sp_shreg.sv
module adc_sp_shreg #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [WIDTH-1:0] word_i,
   input  logic             shift_i,
   input  logic             ser_i,
   output logic             msb_o
);

   logic [WIDTH-1:0] sreg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sreg_q <= '0;
      else if (load_i)  sreg_q <= word_i;
      else if (shift_i) sreg_q <= {sreg_q[WIDTH-2:0], ser_i};
   end

   assign msb_o = sreg_q[WIDTH-1];

   AST_LOAD_MSB: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (msb_o == $past(word_i[WIDTH-1]))); // R8

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
   import adc_sp_pkg::*;
#(
   parameter int WIDTH       = 16,
   parameter int DIV_W       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] result_i,
   input  logic             done_i,
   input  logic             start_i,
   input  logic             ext_clk_sel_i,
   input  logic             clk_inv_i,
   input  logic             sync_inv_i,
   input  logic             rd_during_i,
   input  logic             twos_i,
   input  logic [DIV_W-1:0] div_sel_i,
   input  logic             sclk_i,
   input  logic             cs_n_i,
   input  logic             sdin_i,
   output logic             sclk_o,
   output logic             sync_o,
   output logic             sdout_o
);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("adc_serial_port: WIDTH must be at least 2");
      end
      if (DIV_W < 1 || DIV_W > 3) begin : g_bad_div
         $error("adc_serial_port: DIV_W must be 1 to 3");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("adc_serial_port: SYNC_STAGES must be at least 2");
      end
   endgenerate

   port_mode_t mode;
   logic       is_slave;

   assign mode = '{src:       clk_src_e'(ext_clk_sel_i),
                   inv_clk:   clk_inv_i,
                   inv_sync:  sync_inv_i,
                   rd_during: rd_during_i,
                   twos:      twos_i};
   assign is_slave = (mode.src == CLK_SLAVE);

   // stored result and output format
   logic [WIDTH-1:0] held_q;
   logic [WIDTH-1:0] src_word;
   logic [WIDTH-1:0] fmt_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      held_q <= '0;
      else if (done_i) held_q <= result_i;
   end

   assign src_word = (!is_slave && !mode.rd_during) ? result_i : held_q;
   assign fmt_word = {src_word[WIDTH-1] ^ mode.twos, src_word[WIDTH-2:0]};

   // master clock engine
   logic             m_go;
   logic [DIV_W-1:0] m_div;
   logic             m_active;
   logic             m_phase;
   logic             m_shift;

   assign m_go  = !is_slave & (mode.rd_during ? start_i : done_i);
   assign m_div = mode.rd_during ? '0 : div_sel_i;

   adc_sp_master_clk #(
      .WIDTH (WIDTH),
      .DIV_W (DIV_W)
   ) i_master_clk (
      .clk      (clk),
      .rst_n    (rst_n),
      .go_i     (m_go),
      .div_i    (m_div),
      .active_o (m_active),
      .phase_o  (m_phase),
      .shift_o  (m_shift)
   );

   // slave input synchronizers
   logic sclk_s, cs_n_s, sdin_s;
   logic sclk_d, cs_n_d;

   adc_sp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_sclk (
      .clk (clk), .rst_n (rst_n), .d_i (sclk_i), .q_o (sclk_s));
   adc_sp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_cs (
      .clk (clk), .rst_n (rst_n), .d_i (cs_n_i), .q_o (cs_n_s));
   adc_sp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_sdin (
      .clk (clk), .rst_n (rst_n), .d_i (sdin_i), .q_o (sdin_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         cs_n_d <= 1'b1;
      end else begin
         sclk_d <= sclk_s;
         cs_n_d <= cs_n_s;
      end
   end

   logic cs_fall, act_edge, s_load, s_shift;

   assign cs_fall  = !cs_n_s & cs_n_d;
   assign act_edge = mode.inv_clk ? (!sclk_s & sclk_d) : (sclk_s & !sclk_d);
   assign s_load   = is_slave & cs_fall;
   assign s_shift  = is_slave & !cs_n_s & act_edge & !cs_fall;

   // shared shift register
   logic sr_load, sr_shift, sr_ser, sr_msb;

   assign sr_load  = is_slave ? s_load  : (m_go & !m_active);
   assign sr_shift = is_slave ? s_shift : m_shift;
   assign sr_ser   = is_slave & sdin_s;

   adc_sp_shreg #(.WIDTH(WIDTH)) i_shreg (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (sr_load),
      .word_i  (fmt_word),
      .shift_i (sr_shift),
      .ser_i   (sr_ser),
      .msb_o   (sr_msb)
   );

   assign sdout_o = is_slave ? (!cs_n_s & sr_msb) : (m_active & sr_msb);
   assign sclk_o  = m_phase ^ mode.inv_clk;
   assign sync_o  = m_active ^ mode.inv_sync;

   AST_SLAVE_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (is_slave && $past(is_slave) && !$past(m_active)) |-> !m_active); // R11

endmodule

// File: tb/test_adc_serial_port.sv
`timescale 1ns/1ps
module test_adc_serial_port;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] result_i = '0;
   logic        done_i = 1'b0, start_i = 1'b0;
   logic        ext_clk_sel_i = 1'b0, clk_inv_i = 1'b0, sync_inv_i = 1'b0;
   logic        rd_during_i = 1'b0, twos_i = 1'b0;
   logic [1:0]  div_sel_i = '0;
   logic        sclk_i = 1'b0, cs_n_i = 1'b1, sdin_i = 1'b0;
   logic        sclk_o, sync_o, sdout_o;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   adc_serial_port i_adc_serial_port (
      .clk (clk), .rst_n (rst_n), .result_i (result_i), .done_i (done_i),
      .start_i (start_i), .ext_clk_sel_i (ext_clk_sel_i), .clk_inv_i (clk_inv_i),
      .sync_inv_i (sync_inv_i), .rd_during_i (rd_during_i), .twos_i (twos_i),
      .div_sel_i (div_sel_i), .sclk_i (sclk_i), .cs_n_i (cs_n_i), .sdin_i (sdin_i),
      .sclk_o (sclk_o), .sync_o (sync_o), .sdout_o (sdout_o));

   // fields: [21] rd_during [20:19] div [18] clk_inv [17] sync_inv [16] twos [15:0] word
   localparam int NVEC = 8;
   localparam logic [21:0] VEC [NVEC] = '{
      {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 16'hA5C3},
      {1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 16'h1234},
      {1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 16'hFFFF},
      {1'b0, 2'd3, 1'b0, 1'b1, 1'b1, 16'h8001},
      {1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 16'h0F0F},
      {1'b1, 2'd0, 1'b1, 1'b1, 1'b1, 16'h7FFE},
      {1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 16'h0000},
      {1'b0, 2'd1, 1'b0, 1'b1, 1'b1, 16'hC6D1}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] fmt(input logic [15:0] w, input logic tc);
      return {w[15] ^ tc, w[14:0]};
   endfunction

   task automatic pulse(input bit is_done, input logic [15:0] w);
      @(negedge clk);
      result_i = w;
      if (is_done) done_i = 1'b1; else start_i = 1'b1;
      @(negedge clk);
      done_i = 1'b0;
      start_i = 1'b0;
   endtask

   // receives one master frame on the active edges of sclk_o
   task automatic master_frame(input logic inv_clk, input logic inv_sync, input int exp_per,
                               output logic [15:0] got, output bit per_ok, output bit sync_ok);
      int   nb = 0;
      int   t = 0;
      int   last = -1;
      logic prev;
      got = '0;
      per_ok = 1;
      sync_ok = 1;
      prev = sclk_o;
      while (nb < 16 && t < 2000) begin
         @(negedge clk);
         t++;
         if (sclk_o !== prev && sclk_o === ~inv_clk) begin
            got = {got[14:0], sdout_o};
            if (sync_o !== ~inv_sync) sync_ok = 0;
            if (last >= 0 && (t - last) != exp_per) per_ok = 0;
            last = t;
            nb++;
         end
         prev = sclk_o;
      end
      if (nb != 16) per_ok = 0;
   endtask

   // slave transfer: nsh active edges, samples taken before each next edge
   task automatic slave_xfer(input logic inv, input int nsh, input logic [15:0] dstream,
                             output logic [31:0] got);
      got = '0;
      @(negedge clk);
      sclk_i = inv;
      sdin_i = dstream[15];
      repeat (4) @(negedge clk);
      cs_n_i = 1'b0;
      repeat (8) @(negedge clk);
      got[31] = sdout_o;
      for (int j = 1; j <= nsh; j++) begin
         sclk_i = ~inv;
         repeat (8) @(negedge clk);
         sclk_i = inv;
         sdin_i = (j < 16) ? dstream[15-j] : 1'b0;
         repeat (8) @(negedge clk);
         got[31-j] = sdout_o;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [15:0] got16;
      logic [31:0] got32;
      bit per_ok, sync_ok, quiet;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 reset sdout", sdout_o, 0);
      chk("R1 reset sclk", sclk_o, 0);
      chk("R1 reset sync", sync_o, 0);
      clk_inv_i = 1'b1;
      sync_inv_i = 1'b1;
      @(negedge clk);
      chk("R1 idle sclk inverted", sclk_o, 1);
      chk("R1 idle sync inverted", sync_o, 1);

      // master vector table
      for (int v = 0; v < NVEC; v++) begin
         logic [21:0] e;
         int per;
         e = VEC[v];
         rd_during_i = e[21];
         div_sel_i   = e[20:19];
         clk_inv_i   = e[18];
         sync_inv_i  = e[17];
         twos_i      = e[16];
         per = e[21] ? 2 : (2 << e[20:19]);
         repeat (3) @(negedge clk);
         chk("R6 idle sclk level", sclk_o, e[18]);
         chk("R5 idle sync level", sync_o, e[17]);
         if (e[21]) begin
            pulse(1'b1, e[15:0]);
            quiet = 1;
            for (int k = 0; k < 12; k++) begin
               @(negedge clk);
               if (sync_o !== e[17] || sclk_o !== e[18]) quiet = 0;
            end
            chk("R7 done starts no frame", quiet, 1);
            pulse(1'b0, 16'h0000);
         end else begin
            pulse(1'b1, e[15:0]);
         end
         master_frame(e[18], e[17], per, got16, per_ok, sync_ok);
         chk("R2 R3 master word", got16, fmt(e[15:0], e[16]));
         chk("R4 clock period", per_ok, 1);
         chk("R5 sync active in frame", sync_ok, 1);
         repeat (40) @(negedge clk);
         chk("R5 sync inactive after frame", sync_o, e[17]);
         chk("R6 sclk idle after frame", sclk_o, e[18]);
         chk("R1 sdout idle after frame", sdout_o, 0);
      end

      // R7: previous result is sent, not the live input
      rd_during_i = 1'b1; div_sel_i = 2'd2; clk_inv_i = 1'b0; sync_inv_i = 1'b0; twos_i = 1'b0;
      pulse(1'b1, 16'h1357);
      @(negedge clk);
      result_i = 16'h2468;
      repeat (4) @(negedge clk);
      pulse(1'b0, 16'h2468);
      master_frame(1'b0, 1'b0, 2, got16, per_ok, sync_ok);
      chk("R7 previous word sent", got16, 16'h1357);
      chk("R4 read-during period ignores divide", per_ok, 1);
      repeat (40) @(negedge clk);

      // R11: slave mode ignores strobes on the master side
      ext_clk_sel_i = 1'b1; rd_during_i = 1'b0; clk_inv_i = 1'b1; sync_inv_i = 1'b1;
      repeat (2) @(negedge clk);
      pulse(1'b1, 16'hB38E);
      pulse(1'b0, 16'hB38E);
      quiet = 1;
      for (int k = 0; k < 60; k++) begin
         @(negedge clk);
         if (sclk_o !== 1'b1 || sync_o !== 1'b1 || sdout_o !== 1'b0) quiet = 0;
      end
      chk("R11 slave mode master outputs idle", quiet, 1);

      // R8, R9: slave, rising active edge, offset binary
      clk_inv_i = 1'b0; sync_inv_i = 1'b0; twos_i = 1'b0;
      slave_xfer(1'b0, 31, 16'h5A96, got32);
      chk("R8 slave word rising edge", got32[31:16], 16'hB38E);
      chk("R9 daisy chain after 16 edges", got32[15:0], 16'h5A96);
      cs_n_i = 1'b1;
      repeat (8) @(negedge clk);
      chk("R10 sdout low with cs high", sdout_o, 0);

      // R8, R9: slave, falling active edge, two's complement
      clk_inv_i = 1'b1; twos_i = 1'b1;
      pulse(1'b1, 16'h4C21);
      slave_xfer(1'b1, 31, 16'hE00F, got32);
      chk("R8 R3 slave word falling edge", got32[31:16], fmt(16'h4C21, 1'b1));
      chk("R9 daisy chain falling edge", got32[15:0], 16'hE00F);
      cs_n_i = 1'b1;
      repeat (8) @(negedge clk);

      // R10: abort mid-frame and restart
      clk_inv_i = 1'b0; twos_i = 1'b0;
      pulse(1'b1, 16'h9A5B);
      slave_xfer(1'b0, 5, 16'h0000, got32);
      chk("R10 partial frame bits", got32[31:26], 6'b100110);
      cs_n_i = 1'b1;
      repeat (8) @(negedge clk);
      chk("R10 sdout low after abort", sdout_o, 0);
      slave_xfer(1'b0, 15, 16'h0000, got32);
      chk("R10 restart from msb", got32[31:16], 16'h9A5B);
      cs_n_i = 1'b1;
      repeat (8) @(negedge clk);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule